// File: doc/BRIEF.md
# Single-Input-Change Test Pattern Generator

This block drives a circuit under test with pseudorandom stimulus that switches very little from one clock to the next. A maximal-length shift register with linear feedback supplies a random base pattern. Beside it runs a twisted-ring counter of the same width. The applied vector is the bitwise XOR of the two. The base pattern is held while the ring walks through its full 2·WIDTH-state loop. It advances by one step only on the clock where the ring falls back to all zeros.

As a result, within one base pattern each applied vector differs from the one before it in exactly one bit. The only large jumps happen when a new base pattern takes over. A seed can be loaded at any time, and that restarts the ring. An enable input pauses the whole generator. The feedback polynomial is chosen by parameters: either a trinomial or a pentanomial.

Top module: `sic_tpg`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) has priority over every other input. It puts the base register at `DEFAULT_SEED` and the ring at zero, so `test_vec` equals `DEFAULT_SEED` after the edge.
- R2: A clock edge with `seed_load` high and `rst` low loads `seed_value` into the base register and clears the ring, whatever the state of `en`. `test_vec` then equals the loaded seed.
- R3: A load of an all-zero `seed_value` installs `DEFAULT_SEED` instead. The base register never holds zero.
- R4: With `en` low, and neither `rst` nor `seed_load` high, both registers keep their values and `test_vec` does not change. Paused cycles do not count toward the 2·WIDTH period.
- R5: Each enabled edge shifts the ring left by one and feeds the inverted top bit into bit 0. After k enabled edges from zero, with k ≤ WIDTH, bits k-1..0 are set. After WIDTH+j edges, bits j-1..0 are clear again. Within one base pattern, consecutive vectors differ in exactly one bit.
- R6: The base register advances on exactly every 2·WIDTH-th enabled edge after a load or reset. That edge is the one that takes the ring from only-the-top-bit-set back to zero. `test_vec` then equals the new base pattern.
- R7: A base step shifts left by one. The new bit 0 is bit WIDTH-1 XOR bit TAP1-1, XOR bits TAP2-1 and TAP3-1 when those are nonzero. The default is WIDTH=36, TAP1=25 (x^36+x^25+1) and DEFAULT_SEED=36'hF101BB288.
- R8: With WIDTH=4 and TAP1=3, the base sequence starting from 1 first returns to 1 after 15 steps, which is 120 enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_value` and restart the ring |
| seed_value | input | WIDTH | Seed for the base register |
| en | input | 1 | Step the generator when high |
| test_vec | output | WIDTH | Applied test vector (base XOR ring) |

## Verification
The bench builds two copies of the block. One uses the default 36-bit trinomial configuration. There the 72-cycle pattern period, the one-bit stepping inside a period and the known first steps from hand-picked seeds can all be checked exactly. The other uses WIDTH=4 with TAP1=3, whose short 8-cycle ring and 15-state base sequence make it practical to walk the complete maximal-length loop and confirm the return to the seed.

// File: rtl/sic_pkg.sv
package sic_pkg;
   // Operation applied to both registers on a clock edge, in priority order.
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_STEP = 2'd1,
      OP_LOAD = 2'd2,
      OP_INIT = 2'd3
   } sic_op_e;

   localparam int SIC_MIN_WIDTH = 3;
endpackage

// File: rtl/sic_ring.sv
module sic_ring
   import sic_pkg::*;
#(
   parameter int WIDTH = 36
) (
   input  logic             clk,
   input  sic_op_e          op,
   output logic [WIDTH-1:0] ring_q,
   output logic             wrap
);
   localparam logic [WIDTH-1:0] LAST_STATE = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] shifted;

   // Twisted-ring step: shift left, inverted top bit re-enters at bit 0.
   assign shifted[0] = ~ring_q[WIDTH-1];
   for (genvar i = 1; i < WIDTH; i++) begin : g_shift
      assign shifted[i] = ring_q[i-1];
   end

   always_ff @(posedge clk) begin
      case (op)
         OP_INIT, OP_LOAD: ring_q <= '0;
         OP_STEP:          ring_q <= shifted;
         default:          ring_q <= ring_q;
      endcase
   end

   // Ring is on its last state; the next step returns it to zero.
   assign wrap = (ring_q == LAST_STATE);
endmodule

// File: rtl/sic_lfsr.sv
module sic_lfsr
   import sic_pkg::*;
#(
   parameter int               WIDTH        = 36,
   parameter int               TAP1         = 25,
   parameter int               TAP2         = 0,
   parameter int               TAP3         = 0,
   parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(64'hF101BB288)
) (
   input  logic             clk,
   input  sic_op_e          op,
   input  logic             advance,
   input  logic [WIDTH-1:0] seed_in,
   output logic [WIDTH-1:0] state_q
);
   logic             fb;
   logic [WIDTH-1:0] load_val;

   if (TAP2 == 0) begin : g_trinomial
      assign fb = state_q[WIDTH-1] ^ state_q[TAP1-1];
   end else begin : g_pentanomial
      assign fb = state_q[WIDTH-1] ^ state_q[TAP1-1]
                ^ state_q[TAP2-1]  ^ state_q[TAP3-1];
   end

   // A zero seed would lock the register; substitute the default.
   assign load_val = (seed_in == '0) ? DEFAULT_SEED : seed_in;

   always_ff @(posedge clk) begin
      case (op)
         OP_INIT: state_q <= DEFAULT_SEED;
         OP_LOAD: state_q <= load_val;
         OP_STEP: if (advance) state_q <= {state_q[WIDTH-2:0], fb};
         default: state_q <= state_q;
      endcase
   end
endmodule

// File: rtl/sic_tpg.sv
module sic_tpg
   import sic_pkg::*;
#(
   parameter int               WIDTH        = 36,
   parameter int               TAP1         = 25,
   parameter int               TAP2         = 0,
   parameter int               TAP3         = 0,
   parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(64'hF101BB288)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seed_load,
   input  logic [WIDTH-1:0] seed_value,
   input  logic             en,
   output logic [WIDTH-1:0] test_vec
);
   // Elaboration-time parameter checks.
   if (WIDTH < SIC_MIN_WIDTH) begin : g_bad_width
      $error("sic_tpg: WIDTH must be at least %0d", SIC_MIN_WIDTH);
   end
   if (TAP1 < 1 || TAP1 >= WIDTH) begin : g_bad_tap1
      $error("sic_tpg: TAP1 must lie in 1..WIDTH-1");
   end
   if ((TAP2 == 0) != (TAP3 == 0)) begin : g_bad_tap_pair
      $error("sic_tpg: TAP2 and TAP3 must both be zero or both be set");
   end
   if (TAP2 != 0 && (TAP2 >= WIDTH || TAP3 >= WIDTH)) begin : g_bad_tap_hi
      $error("sic_tpg: TAP2 and TAP3 must be below WIDTH");
   end
   if (DEFAULT_SEED == '0) begin : g_bad_seed
      $error("sic_tpg: DEFAULT_SEED must be nonzero");
   end

   sic_op_e          op;
   logic [WIDTH-1:0] lfsr_q;
   logic [WIDTH-1:0] ring_q;
   logic             ring_wrap;

   always_comb begin
      if (rst)            op = OP_INIT;
      else if (seed_load) op = OP_LOAD;
      else if (en)        op = OP_STEP;
      else                op = OP_HOLD;
   end

   sic_ring #(.WIDTH(WIDTH)) u_ring (
      .clk    (clk),
      .op     (op),
      .ring_q (ring_q),
      .wrap   (ring_wrap)
   );

   sic_lfsr #(
      .WIDTH        (WIDTH),
      .TAP1         (TAP1),
      .TAP2         (TAP2),
      .TAP3         (TAP3),
      .DEFAULT_SEED (DEFAULT_SEED)
   ) u_lfsr (
      .clk     (clk),
      .op      (op),
      .advance (ring_wrap),
      .seed_in (seed_value),
      .state_q (lfsr_q)
   );

   assign test_vec = lfsr_q ^ ring_q;
endmodule

// File: rtl/sic_tpg_chk.sv
module sic_tpg_chk #(
   parameter int WIDTH = 36
) (
   input logic             clk,
   input logic             rst,
   input logic             seed_load,
   input logic [WIDTH-1:0] seed_value,
   input logic             en,
   input logic [WIDTH-1:0] lfsr_q,
   input logic [WIDTH-1:0] ring_q
);
   localparam int               PERIOD = 2 * WIDTH;
   localparam int               CW     = $clog2(PERIOD);
   localparam logic [WIDTH-1:0] TOP    = {1'b1, {(WIDTH-1){1'b0}}};

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || seed_load)                cnt <= '0;
      else if (en && cnt == CW'(PERIOD-1)) cnt <= '0;
      else if (en)                         cnt <= cnt + 1'b1;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      (seed_load && seed_value != '0) |=> (ring_q == '0 && lfsr_q == $past(seed_value)));

   p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> lfsr_q != '0);

   p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
      (!en && !seed_load) |=> ($stable(lfsr_q) && $stable(ring_q)));

   p_ring_onestep_r5: assert property (@(posedge clk) disable iff (rst)
      (en && !seed_load) |=> $countones(ring_q ^ $past(ring_q)) == 1);

   p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (en && !seed_load && ring_q == TOP) |=> (ring_q == '0 && lfsr_q != $past(lfsr_q)));

   p_period_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!seed_load) && lfsr_q != $past(lfsr_q)) |-> $past(cnt) == CW'(PERIOD-1));
endmodule

bind sic_tpg sic_tpg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .seed_load  (seed_load),
   .seed_value (seed_value),
   .en         (en),
   .lfsr_q     (lfsr_q),
   .ring_q     (ring_q)
);

// File: tb/sic_tpg_bench.sv
module sic_tpg_bench;
   localparam int          W     = 36;
   localparam int          TAP   = 25;
   localparam logic [35:0] DSEED = 36'hF101BB288;

   typedef struct packed {
      logic [35:0] seed;
      logic [15:0] run;
   } vec_t;

   // Stimulus table: seed to load and number of enabled edges to walk.
   localparam vec_t TBL [4] = '{
      '{seed: 36'hF101BB288, run: 16'd37},
      '{seed: 36'h000000001, run: 16'd72},
      '{seed: 36'h800000000, run: 16'd150},
      '{seed: 36'hAAAAAAAAA, run: 16'd217}
   };

   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst, ld, en;
   logic [35:0] seed;
   logic [35:0] vec;
   logic        s_rst, s_en;
   logic [3:0]  s_vec;

   sic_tpg u_sic_tpg (
      .clk(clk), .rst(rst), .seed_load(ld), .seed_value(seed), .en(en), .test_vec(vec)
   );

   sic_tpg #(.WIDTH(4), .TAP1(3), .DEFAULT_SEED(4'h1)) u_sic_tpg_w4 (
      .clk(clk), .rst(s_rst), .seed_load(1'b0), .seed_value(4'h0), .en(s_en), .test_vec(s_vec)
   );

   int checks = 0;
   int fails  = 0;
   int sic_viol = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] m_mask(input int w);
      logic [63:0] m;
      m = (64'd1 << w) - 64'd1;
      return m[35:0];
   endfunction

   function automatic logic [35:0] m_step(input logic [35:0] x, input int w, input int tap);
      logic [35:0] r;
      r = (x << 1) & m_mask(w);
      r[0] = x[w-1] ^ x[tap-1];
      return r;
   endfunction

   function automatic logic [35:0] m_ring(input int kk, input int w);
      logic [63:0] r;
      if (kk <= w) r = (64'd1 << kk) - 64'd1;
      else         r = {28'd0, m_mask(w)} & ~((64'd1 << (kk - w)) - 64'd1);
      return r[35:0];
   endfunction

   function automatic logic [35:0] m_expect(input logic [35:0] s, input int k, input int w, input int tap);
      logic [35:0] l;
      l = s;
      for (int i = 0; i < k / (2 * w); i++) l = m_step(l, w, tap);
      return l ^ m_ring(k % (2 * w), w);
   endfunction

   task automatic load_seed(input logic [35:0] s);
      ld = 1'b1; en = 1'b0; seed = s;
      @(negedge clk);
      ld = 1'b0;
   endtask

   task automatic steps(input int n);
      en = 1'b1;
      repeat (n) @(negedge clk);
      en = 1'b0;
   endtask

   // Walk n enabled edges from a fresh load, comparing every vector to the model.
   task automatic run_check(input logic [35:0] s, input int n, input string req);
      logic [35:0] prev, first_act, first_exp;
      bit          bad;
      bad = 1'b0; first_act = '0; first_exp = '0;
      prev = vec;
      en = 1'b1;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (vec !== m_expect(s, k, W, TAP) && !bad) begin
            bad = 1'b1; first_act = vec; first_exp = m_expect(s, k, W, TAP);
         end
         if ((k % (2 * W)) != 0 && $countones(vec ^ prev) != 1) sic_viol++;
         prev = vec;
      end
      en = 1'b0;
      chk(!bad, req, {28'd0, first_act}, {28'd0, first_exp});
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [3:0]  s_hist;
      bit          s_bad, s_early;
      logic [35:0] hold_exp;
      bit          hold_bad;

      rst = 1'b1; ld = 1'b0; en = 1'b0; seed = '0;
      s_rst = 1'b1; s_en = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0; s_rst = 1'b0;

      // R1: reset state
      chk(vec === DSEED, "R1 reset vector", {28'd0, vec}, {28'd0, DSEED});
      chk(s_vec === 4'h1, "R1 reset vector w4", {60'd0, s_vec}, 64'h1);

      // R8: full maximal loop of the 4-bit copy
      s_bad = 1'b0; s_early = 1'b0; s_hist = '0;
      s_en = 1'b1;
      for (int k = 1; k <= 120; k++) begin
         @(negedge clk);
         if ({32'd0, s_vec} !== m_expect(36'h1, k, 4, 3)) s_bad = 1'b1;
         if (k % 8 == 0 && k < 120 && s_vec == 4'h1) s_early = 1'b1;
         if (k == 120) s_hist = s_vec;
      end
      s_en = 1'b0;
      chk(!s_bad, "R8 w4 sequence matches model", {63'd0, s_bad}, 64'd0);
      chk(!s_early, "R8 w4 no early return to seed", {63'd0, s_early}, 64'd0);
      chk(s_hist == 4'h1, "R8 w4 returns to seed after 120 edges", {60'd0, s_hist}, 64'h1);

      // Table walk: R2 load, R5/R6/R7 sequence against model
      for (int i = 0; i < 4; i++) begin
         load_seed(TBL[i].seed);
         chk(vec === TBL[i].seed, "R2 vector equals loaded seed", {28'd0, vec}, {28'd0, TBL[i].seed});
         run_check(TBL[i].seed, int'(TBL[i].run), "R5 R6 R7 table sequence");
      end
      chk(sic_viol == 0, "R5 one-bit change inside a pattern", sic_viol, 0);

      // R5: ring fill and drain shape from a known seed
      load_seed(36'h000000000 | 36'h100000000);
      steps(36);
      chk(vec === (36'h100000000 ^ 36'hFFFFFFFFF), "R5 ring all ones after WIDTH edges",
          {28'd0, vec}, {28'd0, 36'h100000000 ^ 36'hFFFFFFFFF});

      // R6/R7: hand-derived first advance
      load_seed(36'h800000000);
      steps(71);
      chk(vec === 36'h0, "R6 last ring state before advance", {28'd0, vec}, 64'h0);
      steps(1);
      chk(vec === 36'h000000001, "R7 step of 800000000", {28'd0, vec}, 64'h1);
      load_seed(36'h001000000);
      steps(72);
      chk(vec === 36'h002000001, "R7 step of 001000000", {28'd0, vec}, 64'h002000001);

      // R3: zero seed replaced by default
      load_seed(36'h0);
      chk(vec === DSEED, "R3 zero seed gives default", {28'd0, vec}, {28'd0, DSEED});
      steps(1);
      chk(vec === (DSEED ^ 36'h1), "R3 default seed then steps", {28'd0, vec}, {28'd0, DSEED ^ 36'h1});

      // R4: enable low freezes and does not count toward the period
      load_seed(36'hAAAAAAAAA);
      steps(5);
      hold_exp = m_expect(36'hAAAAAAAAA, 5, W, TAP);
      hold_bad = 1'b0;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         if (vec !== hold_exp) hold_bad = 1'b1;
      end
      chk(!hold_bad, "R4 vector frozen with enable low", {28'd0, vec}, {28'd0, hold_exp});
      steps(67);
      chk(vec === m_expect(36'hAAAAAAAAA, 72, W, TAP), "R4 R6 paused cycles not counted",
          {28'd0, vec}, {28'd0, m_expect(36'hAAAAAAAAA, 72, W, TAP)});

      // R2: load mid-pattern with enable high restarts the ring
      load_seed(36'h123456789);
      steps(10);
      ld = 1'b1; en = 1'b1; seed = 36'h0F0F0F0F0;
      @(negedge clk);
      ld = 1'b0; en = 1'b0;
      chk(vec === 36'h0F0F0F0F0, "R2 load overrides enable", {28'd0, vec}, 64'h0F0F0F0F0);

      // R1: reset beats load and enable
      steps(9);
      rst = 1'b1; ld = 1'b1; en = 1'b1; seed = 36'h123;
      @(negedge clk);
      rst = 1'b0; ld = 1'b0; en = 1'b0;
      chk(vec === DSEED, "R1 reset priority", {28'd0, vec}, {28'd0, DSEED});

      summary();
      $finish;
   end
endmodule